// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. A 16x oversampling tick paces it. The line goes through a short synchronizer. A high-to-low transition on the idle line opens a frame, and a majority vote over three ticks near the middle of each bit decides the value of that bit. The character width and the parity checking come from a control byte, and the transmitter on the other side of the link decodes the same byte. The stop-bit-count field in that byte is meant for the transmitter only, and reception ignores it.

A finished character is held together with its parity-error and framing-error flags until it is read through a one-byte read port. Characters of five to eight bits take a single read. Nine-bit characters take two reads, and the character size code sets whether the low byte or the high byte comes out first. Reading the last byte of a character clears the held flags. A character that completes while an older one is still held replaces the older one.

Top module: `async_char_rx`

## Requirements
- R1: The control byte is captured when a start edge is seen. Its bits [2:0] give the character size: codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, codes 6 and 7 select 9 bits, and codes 4 and 5 act as 8 bits. Data arrives least significant bit first, and every held bit above the character width reads as 0.
- R2: Control bits [5:4] select the parity mode: 2 is even and 3 is odd. When parity is enabled, one parity bit follows the data. Even mode expects that bit to equal the XOR of the data bits, and odd mode expects its complement. A mismatch sets `par_err`.
- R3: Parity codes 0 and 1 disable parity. No parity bit is expected, and `par_err` stays 0.
- R4: Control bit [3] (stop count) has no effect on reception. Only the first stop bit is sampled, and a 0 there sets `frm_err`.
- R5: A frame opens only when the sampled line goes from 1 to 0 on consecutive ticks. If the vote at the middle of the start bit reads 1, the start is dropped and no output changes.
- R6: Counting the start-edge tick as tick 0 of the start bit, every bit is the majority of the line at ticks 7, 8 and 9 of that bit. A wrong level at only one of those ticks does not change the bit.
- R7: `rx_full` rises at the first-stop-bit vote. A `rd_strobe` pulse while full consumes one byte. For widths of 8 bits or fewer, one read clears `rx_full`, `par_err` and `frm_err`. A `rd_strobe` pulse while empty is ignored.
- R8: With size code 6, the first read returns data[7:0] and the second returns {7'b0, data[8]}. Code 7 gives the reverse order. `rx_full` and both flags stay set until the second read.
- R9: A character that completes while another is held overwrites it, including its flags, and restarts the read order at the first byte.
- R10: After reset, `rx_full`, `par_err` and `frm_err` are 0, and `rd_byte` is 0 whenever nothing is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| ctl_byte | input | 8 | Shared control byte (size, stop count, parity) |
| rd_strobe | input | 1 | Consume the byte shown on rd_byte |
| rd_byte | output | 8 | Next byte of the held character |
| rx_full | output | 1 | A character is held |
| par_err | output | 1 | Parity mismatch on the held character |
| frm_err | output | 1 | First stop bit of the held character was 0 |

## Verification
Frames are sent at every character width with varied data. This shows whether the size decode and the bit order are right, and whether stale upper bits are masked. Parity frames are sent in even and odd mode with a correct parity bit and with a flipped one, and with the reserved parity code. These tell a correct parity polarity apart from an inverted one, and a disabled parity bit apart from one that is still expected. Other patterns check start handling and bit voting: a short low pulse and a start bit that is low for only half its length must both be rejected, and a one-tick spike inside a data bit must be outvoted. A zero stop bit, and back-to-back frames with the stop-count bit set but only one stop bit sent, show that framing is checked on the first stop bit alone. Nine-bit characters are read in both byte orders, with a flag set and with a new frame landing between the two reads, to separate the byte order, the flag clearing and the overwrite behaviour.

// File: rtl/async_rx_pkg.sv
`timescale 1ns/1ps
package async_rx_pkg;
  localparam int CHAR_W = 9;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W + 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] nbits;
    logic             par_en;
    logic             par_odd;
    logic             nine;
    logic             hi_first;
  } char_cfg_t;

  // Turn the shared control byte into the receiver's view of the frame.
  function automatic char_cfg_t decode_ctl(input logic [7:0] ctl);
    char_cfg_t c;
    case (ctl[2:0])
      3'd0:    c.nbits = CNT_W'(5);
      3'd1:    c.nbits = CNT_W'(6);
      3'd2:    c.nbits = CNT_W'(7);
      3'd6,
      3'd7:    c.nbits = CNT_W'(9);
      default: c.nbits = CNT_W'(8);
    endcase
    c.par_en   = ctl[5];
    c.par_odd  = ctl[4];
    c.nine     = (ctl[2:1] == 2'b11);
    c.hi_first = ctl[0] & c.nine;
    return c;
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Parity bit the sender should have produced for these data bits.
  function automatic logic parity_ref(input logic [CHAR_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CHAR_W-1:0] d,
                                                  input char_cfg_t c,
                                                  input logic second);
    logic take_hi;
    take_hi = c.nine & (c.hi_first ^ second);
    if (take_hi) return BYTE_W'(d[CHAR_W-1:BYTE_W]);
    return d[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/async_rx_sync.sv
`timescale 1ns/1ps
module async_rx_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= IDLE_LVL;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{IDLE_LVL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/async_rx_engine.sv
`timescale 1ns/1ps
module async_rx_engine
  import async_rx_pkg::*;
#(
  parameter int OS_RATE  = 16,
  parameter int VOTE_MID = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              line_s,
  input  logic [7:0]        ctl,
  output logic              frame_done,
  output logic              start_reject,
  output logic [CHAR_W-1:0] done_data,
  output char_cfg_t         done_cfg,
  output logic              done_pe,
  output logic              done_fe
);
  localparam int TW = $clog2(OS_RATE);
  localparam int BW = $clog2(CHAR_W);
  localparam logic [TW-1:0] T_A   = TW'(VOTE_MID - 1);
  localparam logic [TW-1:0] T_B   = TW'(VOTE_MID);
  localparam logic [TW-1:0] T_C   = TW'(VOTE_MID + 1);
  localparam logic [TW-1:0] T_END = TW'(OS_RATE - 1);

  rx_state_e         state;
  logic [TW-1:0]     tidx;
  logic [BW-1:0]     bitn;
  logic [CHAR_W-1:0] shreg;
  logic              v_a, v_b, prev_s, par_q;
  char_cfg_t         cfg_q;
  logic              vote, at_dec, last_bit;

  assign vote     = vote3(v_a, v_b, line_s);
  assign at_dec   = (tidx == T_C);
  assign last_bit = (CNT_W'(bitn) == cfg_q.nbits - CNT_W'(1));

  assign frame_done   = os_tick && (state == RX_STOP)  && at_dec;
  assign start_reject = os_tick && (state == RX_START) && at_dec && vote;
  assign done_data    = shreg;
  assign done_cfg     = cfg_q;
  assign done_pe      = cfg_q.par_en && (par_q != parity_ref(shreg, cfg_q.par_odd));
  assign done_fe      = !vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      tidx   <= '0;
      bitn   <= '0;
      shreg  <= '0;
      v_a    <= 1'b1;
      v_b    <= 1'b1;
      prev_s <= 1'b1;
      par_q  <= 1'b0;
      cfg_q  <= '0;
    end else if (os_tick) begin
      prev_s <= line_s;
      if (tidx == T_A) v_a <= line_s;
      if (tidx == T_B) v_b <= line_s;
      if (state == RX_IDLE) begin
        if (prev_s && !line_s) begin
          state <= RX_START;
          tidx  <= TW'(1);
          cfg_q <= decode_ctl(ctl);
          shreg <= '0;
          par_q <= 1'b0;
        end
      end else begin
        tidx <= (tidx == T_END) ? '0 : tidx + TW'(1);
        case (state)
          RX_START: begin
            if (at_dec && vote) state <= RX_IDLE;
            else if (tidx == T_END) begin
              state <= RX_DATA;
              bitn  <= '0;
            end
          end
          RX_DATA: begin
            if (at_dec) shreg[bitn] <= vote;
            if (tidx == T_END) begin
              if (last_bit) state <= cfg_q.par_en ? RX_PAR : RX_STOP;
              else          bitn  <= bitn + BW'(1);
            end
          end
          RX_PAR: begin
            if (at_dec) par_q <= vote;
            if (tidx == T_END) state <= RX_STOP;
          end
          RX_STOP: begin
            if (at_dec) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_rx_holder.sv
`timescale 1ns/1ps
module async_rx_holder
  import async_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [CHAR_W-1:0] in_data,
  input  char_cfg_t         in_cfg,
  input  logic              in_pe,
  input  logic              in_fe,
  input  logic              rd_strobe,
  output logic              rx_full,
  output logic              par_err,
  output logic              frm_err,
  output logic [BYTE_W-1:0] rd_byte,
  output char_cfg_t         held_cfg,
  output logic              rd_phase
);
  logic [CHAR_W-1:0] hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full   <= 1'b0;
      par_err   <= 1'b0;
      frm_err   <= 1'b0;
      hold_data <= '0;
      held_cfg  <= '0;
      rd_phase  <= 1'b0;
    end else if (frame_done) begin
      rx_full   <= 1'b1;
      par_err   <= in_pe;
      frm_err   <= in_fe;
      hold_data <= in_data;
      held_cfg  <= in_cfg;
      rd_phase  <= 1'b0;
    end else if (rd_strobe && rx_full) begin
      if (held_cfg.nine && !rd_phase) begin
        rd_phase <= 1'b1;
      end else begin
        rx_full  <= 1'b0;
        par_err  <= 1'b0;
        frm_err  <= 1'b0;
        rd_phase <= 1'b0;
      end
    end
  end

  assign rd_byte = rx_full ? pick_byte(hold_data, held_cfg, rd_phase) : '0;
endmodule

// File: rtl/async_char_rx.sv
`timescale 1ns/1ps
module async_char_rx
  import async_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int VOTE_MID    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic [7:0] ctl_byte,
  input  logic       rd_strobe,
  output logic [7:0] rd_byte,
  output logic       rx_full,
  output logic       par_err,
  output logic       frm_err
);
  logic              line_s;
  logic              frame_done;
  logic              start_reject;
  logic [CHAR_W-1:0] done_data;
  char_cfg_t         done_cfg;
  logic              done_pe, done_fe;
  char_cfg_t         held_cfg;
  logic              rd_phase;

  async_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  async_rx_engine #(.OS_RATE(OS_RATE), .VOTE_MID(VOTE_MID)) eng_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_s(line_s), .ctl(ctl_byte),
    .frame_done(frame_done), .start_reject(start_reject), .done_data(done_data),
    .done_cfg(done_cfg), .done_pe(done_pe), .done_fe(done_fe)
  );

  async_rx_holder hold_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .in_data(done_data),
    .in_cfg(done_cfg), .in_pe(done_pe), .in_fe(done_fe), .rd_strobe(rd_strobe),
    .rx_full(rx_full), .par_err(par_err), .frm_err(frm_err), .rd_byte(rd_byte),
    .held_cfg(held_cfg), .rd_phase(rd_phase)
  );
endmodule

// File: rtl/async_char_rx_chk.sv
`timescale 1ns/1ps
module async_char_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       rx_full,
  input logic       par_err,
  input logic       frm_err,
  input logic [7:0] rd_byte,
  input logic       frame_done,
  input logic       start_reject,
  input logic       held_nine,
  input logic       held_par_en,
  input logic [3:0] held_bits,
  input logic       rd_phase
);
  assert_done_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_full);

  assert_full_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(frame_done));

  assert_flags_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err || frm_err) |-> rx_full);

  assert_short_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rx_full && !held_nine && !frame_done) |=> (!rx_full && !par_err && !frm_err));

  assert_nopar_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !held_par_en) |-> !par_err);

  assert_nine_first_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rx_full && held_nine && !rd_phase && !frame_done) |=> (rx_full && rd_phase));

  assert_width_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !held_nine) |-> ((rd_byte >> held_bits) == 8'd0));

  assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> ($stable(rx_full) || $past(rd_strobe)));
endmodule

bind async_char_rx async_char_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rx_full(rx_full),
  .par_err(par_err), .frm_err(frm_err), .rd_byte(rd_byte),
  .frame_done(frame_done), .start_reject(start_reject),
  .held_nine(held_cfg.nine), .held_par_en(held_cfg.par_en),
  .held_bits(held_cfg.nbits), .rd_phase(rd_phase)
);

// File: tb/async_char_rx_tb.sv
`timescale 1ns/1ps
module async_char_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic [7:0] ctl_byte = 8'h03;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_byte;
  logic       rx_full, par_err, frm_err;

  int n_cmp = 0;
  int n_bad = 0;
  int tcnt  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  // behavioural model of what should be held
  bit       m_full, m_pe, m_fe, m_nine, m_hi, m_phase;
  logic [8:0] m_data;
  logic [8:0] sent_q[$];

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt    <= (tcnt == 3) ? 0 : tcnt + 1;
    os_tick <= (tcnt == 2);
  end

  async_char_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .ctl_byte(ctl_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
    .rx_full(rx_full), .par_err(par_err), .frm_err(frm_err)
  );

  function automatic logic [7:0] m_byte();
    if (!m_full) return 8'd0;
    if (!m_nine) return m_data[7:0];
    if ((m_phase == 1'b0) == m_hi) return {7'd0, m_data[8]};
    return m_data[7:0];
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (cmp_en && !done) begin
      chk("R7", "rx_full", rx_full, m_full);
      chk("R2", "par_err", par_err, m_pe);
      chk("R4", "frm_err", frm_err, m_fe);
      chk("R1", "rd_byte", rd_byte, m_byte());
    end
  end

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(posedge clk iff os_tick);
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] ctl, input logic [8:0] d, input bit flip,
                            input bit stop_v, input int n_stop, input int spike_at);
    int nb;
    logic [8:0] dm;
    logic p;
    ctl_byte = ctl;
    if (ctl[2:0] < 3'd4)       nb = int'(ctl[2:0]) + 5;
    else if (ctl[2:0] >= 3'd6) nb = 9;
    else                       nb = 8;
    dm = d & ((9'h1 << nb) - 9'h1);
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      if (i == spike_at) begin
        hold(dm[i], 8); hold(!dm[i], 1); hold(dm[i], 7);
      end else hold(dm[i], 16);
    end
    if (ctl[5]) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ dm[i];
      p = p ^ ctl[4] ^ flip;
      hold(p, 16);
    end
    cmp_en = 1'b0;
    hold(stop_v, 16);
    rx_line = 1'b1;
    sent_q.push_back(dm);
    m_full  = 1'b1;
    m_data  = dm;
    m_pe    = ctl[5] && flip;
    m_fe    = !stop_v;
    m_nine  = (nb == 9);
    m_hi    = ctl[0];
    m_phase = 1'b0;
    cmp_en  = 1'b1;
    for (int k = 1; k < n_stop; k++) hold(1'b1, 16);
  endtask

  task automatic read_one(input string tag);
    chk(tag, "read byte", rd_byte, m_byte());
    rd_strobe = 1'b1;
    if (m_full) begin
      if (m_nine && !m_phase) m_phase = 1'b1;
      else begin
        m_full = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_phase = 1'b0;
      end
    end
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10", "reset rx_full", rx_full, 0);
    chk("R10", "reset par_err", par_err, 0);
    chk("R10", "reset frm_err", frm_err, 0);
    chk("R10", "reset rd_byte", rd_byte, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    hold(1'b1, 20);

    // R7 read while empty is ignored
    read_one("R7");
    chk("R7", "empty read keeps empty", rx_full, 0);

    // R1 widths
    send_frame(8'h03, 9'h0A5, 0, 1, 1, -1); read_one("R1");
    send_frame(8'h00, 9'h1F6, 0, 1, 1, -1); read_one("R1");
    send_frame(8'h01, 9'h02B, 0, 1, 1, -1); read_one("R1");
    send_frame(8'h02, 9'h0D5, 0, 1, 1, -1); read_one("R1");
    send_frame(8'h04, 9'h1C3, 0, 1, 1, -1); read_one("R1");

    // R2 parity even/odd, good and flipped
    send_frame(8'h22, 9'h05A, 0, 1, 1, -1);
    chk("R2", "even good", par_err, 0); read_one("R2");
    send_frame(8'h22, 9'h05A, 1, 1, 1, -1);
    chk("R2", "even flipped", par_err, 1); read_one("R2");
    chk("R7", "flag cleared by read", par_err, 0);
    send_frame(8'h33, 9'h081, 0, 1, 1, -1);
    chk("R2", "odd good", par_err, 0); read_one("R2");
    send_frame(8'h31, 9'h02C, 1, 1, 1, -1);
    chk("R2", "odd flipped", par_err, 1); read_one("R2");

    // R3 reserved parity code: no parity bit
    send_frame(8'h13, 9'h0E7, 0, 1, 1, -1);
    chk("R3", "parity off", par_err, 0); read_one("R3");

    // R4 framing and stop count ignored
    send_frame(8'h03, 9'h044, 0, 0, 1, -1);
    chk("R4", "zero stop", frm_err, 1); read_one("R4");
    send_frame(8'h0B, 9'h03C, 0, 1, 2, -1);
    chk("R4", "two stops", frm_err, 0); read_one("R4");
    send_frame(8'h0B, 9'h096, 0, 1, 1, -1);
    send_frame(8'h03, 9'h055, 0, 1, 1, -1);
    chk("R9", "overwrite data", rd_byte, 8'h55);
    chk("R4", "single stop back to back", frm_err, 0);
    read_one("R9");

    // R5 glitches on the idle line
    hold(1'b0, 3); hold(1'b1, 30);
    chk("R5", "short low", rx_full, 0);
    hold(1'b0, 8); hold(1'b1, 30);
    chk("R5", "half start", rx_full, 0);

    // R6 one-tick spikes inside bits
    send_frame(8'h03, 9'h03C, 0, 1, 1, 2); read_one("R6");
    send_frame(8'h03, 9'h0C3, 0, 1, 1, 7); read_one("R6");

    // R8 nine-bit orders
    send_frame(8'h06, 9'h1A5, 0, 1, 1, -1);
    read_one("R8");
    chk("R8", "still full after first", rx_full, 1);
    read_one("R8");
    send_frame(8'h27, 9'h0F0, 1, 1, 1, -1);
    read_one("R8");
    chk("R8", "flag kept after first", par_err, 1);
    read_one("R8");
    chk("R8", "flag cleared after second", par_err, 0);

    // R9 new character between the two reads
    send_frame(8'h06, 9'h1FF, 0, 1, 1, -1);
    read_one("R9");
    send_frame(8'h07, 9'h101, 0, 1, 1, -1);
    chk("R9", "order restarts", rd_byte, 8'h01);
    read_one("R9");
    read_one("R9");
    chk("R9", "empty at end", rx_full, 0);

    hold(1'b1, 8);
    finish_up();
  end
endmodule